// File: doc/BRIEF.md
# Complex NCO Quadrature Mixer

This block moves a selected slice of a sampled spectrum down to zero frequency. Each accepted sample is multiplied by a complex tone, a cosine and sine pair from a numerically controlled oscillator. The product is the same as multiplying by e^(−jωn), so a component at +ω lands at DC. The oscillator is a 12-bit phase accumulator that steps by a 12-bit tuning word. It feeds a cosine/sine table that is built when the design is elaborated.

The input may be a real stream, where only the I bus carries data, or a complex I/Q stream. A mode bit chosen per sample selects between the two. An enable bit, also per sample, lets samples pass unchanged. They come out after the same number of cycles as mixed samples, so downstream timing does not depend on whether the stage is in use. The oscillator keeps running while samples are bypassed.

Top module: `nco_mixer`

## Requirements
- R1: While reset is held, and after its release until the first output sample, out_valid is 0 and out_i and out_q are 0.
- R2: The 12-bit phase starts at 0 after reset. It adds the tuning word, modulo 4096, only in cycles where in_valid is 1. A sample is mixed with the phase as it stood before that sample's own step. In cycles where in_valid is 0 the tuning word has no effect.
- R3: The oscillator takes table index k from phase bits 11..4, giving 256 entries. It outputs cos = round(32767·cos(2πk/256)) and sin = round(32767·sin(2πk/256)), with halves rounded away from zero.
- R4: When cplx_mode = 1 and mix_en = 1: out_i = I·cos + Q·sin and out_q = Q·cos − I·sin, after the scaling of R6.
- R5: When cplx_mode = 0 and mix_en = 1, in_q is ignored: out_i = I·cos and out_q = −I·sin.
- R6: Each output sum is scaled to the 16-bit sample width as floor((sum + 2^14) / 2^15), which rounds half toward +infinity.
- R7: A scaled result above 32767 gives 32767, and one below −32768 gives −32768.
- R8: out_valid repeats in_valid exactly 3 clock cycles later, in both the mixed and the bypassed case. The outputs hold their value when out_valid is 0.
- R9: When mix_en = 0, out_i and out_q equal that sample's in_i and in_q. The phase still steps for that sample.
- R10: cplx_mode, mix_en and the tuning word are taken with each sample. Changing them from one sample to the next affects only the samples that follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Input I sample, signed |
| in_q | input | 16 | Input Q sample, signed (ignored in real mode) |
| tune_word | input | 12 | Phase step per valid sample |
| cplx_mode | input | 1 | 1 = complex input, 0 = real input |
| mix_en | input | 1 | 1 = mix, 0 = bypass with matched latency |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Output I sample, signed |
| out_q | output | 16 | Output Q sample, signed |

## Verification
A phase register that steps in an idle cycle, or misses a step, does not show up right away. The sample it affects comes out 3 cycles later with the wrong rotation, and every sample after it stays wrong by a constant phase offset. This is why the tests put idle cycles between samples while a stray tuning word is applied. A misaligned pipeline stage shows up in the first sample after a mode or enable change. That sample would carry its neighbour's data or rotation, or arrive a cycle off its 3-cycle slot. A wrong rounding or clamp appears only at specific phases and amplitudes, so the tests steer the phase to 0°, 45° and 90° with chosen amplitudes.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Table entry: round(amp * cos/sin(2*pi*k/n)), halves away from zero.
  function automatic int lut_val(input int k, input int n, input int amp, input bit want_sin);
    real ang;
    real v;
    ang = TWO_PI * k / n;
    v   = want_sin ? $sin(ang) : $cos(ang);
    v   = v * amp;
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PH_W   = 12,
  parameter int LUT_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [PH_W-1:0]   ftw,
  output logic [LUT_AW-1:0] lut_addr
);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (step) phase <= phase + ftw;
  end

  assign lut_addr = phase[PH_W-1 -: LUT_AW];

  // R2: an idle cycle leaves the phase where it was
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(phase));

  // R2: a valid cycle advances by exactly the word it carried
  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> phase == PH_W'($past(phase) + $past(ftw)));

endmodule

// File: rtl/nco_sincos_rom.sv
module nco_sincos_rom #(
  parameter int DATA_W = 16,
  parameter int LUT_AW = 8
) (
  input  logic                     clk,
  input  logic [LUT_AW-1:0]        addr,
  output logic signed [DATA_W-1:0] cos_o,
  output logic signed [DATA_W-1:0] sin_o
);

  localparam int LUT_N = 1 << LUT_AW;
  localparam int AMP   = (1 << (DATA_W-1)) - 1;

  logic signed [DATA_W-1:0] cos_tab [LUT_N];
  logic signed [DATA_W-1:0] sin_tab [LUT_N];

  for (genvar k = 0; k < LUT_N; k++) begin : g_tab
    localparam int CV = nco_mix_pkg::lut_val(k, LUT_N, AMP, 1'b0);
    localparam int SV = nco_mix_pkg::lut_val(k, LUT_N, AMP, 1'b1);
    assign cos_tab[k] = DATA_W'(CV);
    assign sin_tab[k] = DATA_W'(SV);
  end

  always_ff @(posedge clk) begin
    cos_o <= cos_tab[addr];
    sin_o <= sin_tab[addr];
  end

endmodule

// File: rtl/nco_cmult.sv
module nco_cmult #(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     v1,
  input  logic                     en1,
  input  logic                     cplx1,
  input  logic signed [DATA_W-1:0] i1,
  input  logic signed [DATA_W-1:0] q1,
  input  logic signed [DATA_W-1:0] c1,
  input  logic signed [DATA_W-1:0] s1,
  output logic                     v_out,
  output logic signed [DATA_W-1:0] i_out,
  output logic signed [DATA_W-1:0] q_out
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = PROD_W + 1;
  localparam logic signed [ACC_W-1:0] RND  = ACC_W'(64'sd1 <<< (DATA_W-2));
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (DATA_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = ACC_W'(-(64'sd1 <<< (DATA_W-1)));

  // scale back by 2^(DATA_W-1), round half up, clamp to the sample range
  function automatic logic signed [DATA_W-1:0] round_sat(input logic signed [ACC_W-1:0] s);
    logic signed [ACC_W-1:0] r;
    r = (s + RND) >>> (DATA_W-1);
    if (r > MAXV) return MAXV[DATA_W-1:0];
    if (r < MINV) return MINV[DATA_W-1:0];
    return r[DATA_W-1:0];
  endfunction

  logic signed [DATA_W-1:0] q_eff;
  assign q_eff = cplx1 ? q1 : '0;

  logic                     v2, en2;
  logic signed [PROD_W-1:0] p_ic, p_qs, p_qc, p_is;
  logic signed [DATA_W-1:0] byp_i, byp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2    <= 1'b0;
      en2   <= 1'b0;
      p_ic  <= '0;
      p_qs  <= '0;
      p_qc  <= '0;
      p_is  <= '0;
      byp_i <= '0;
      byp_q <= '0;
    end else begin
      v2 <= v1;
      if (v1) begin
        en2   <= en1;
        p_ic  <= i1 * c1;
        p_qs  <= q_eff * s1;
        p_qc  <= q_eff * c1;
        p_is  <= i1 * s1;
        byp_i <= i1;
        byp_q <= q1;
      end
    end
  end

  logic signed [ACC_W-1:0] sum_i, sum_q;
  assign sum_i = ACC_W'(p_ic) + ACC_W'(p_qs);
  assign sum_q = ACC_W'(p_qc) - ACC_W'(p_is);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out <= 1'b0;
      i_out <= '0;
      q_out <= '0;
    end else begin
      v_out <= v2;
      if (v2) begin
        i_out <= en2 ? round_sat(sum_i) : byp_i;
        q_out <= en2 ? round_sat(sum_q) : byp_q;
      end
    end
  end

  // R8: outputs hold between samples
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !v2 |=> ($stable(i_out) && $stable(q_out)));

endmodule

// File: rtl/nco_mixer.sv
module nco_mixer #(
  parameter int DATA_W = 16,
  parameter int PH_W   = 12,
  parameter int LUT_AW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  input  logic [PH_W-1:0]          tune_word,
  input  logic                     cplx_mode,
  input  logic                     mix_en,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q
);

  logic [LUT_AW-1:0]        lut_addr;
  logic signed [DATA_W-1:0] tone_cos, tone_sin;

  nco_phase_acc #(.PH_W(PH_W), .LUT_AW(LUT_AW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (in_valid),
    .ftw      (tune_word),
    .lut_addr (lut_addr)
  );

  nco_sincos_rom #(.DATA_W(DATA_W), .LUT_AW(LUT_AW)) u_rom (
    .clk   (clk),
    .addr  (lut_addr),
    .cos_o (tone_cos),
    .sin_o (tone_sin)
  );

  // stage 1: sample and controls, aligned with the registered table read
  logic                     s1_v, s1_en, s1_cplx;
  logic signed [DATA_W-1:0] s1_i, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_en   <= 1'b0;
      s1_cplx <= 1'b0;
      s1_i    <= '0;
      s1_q    <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_en   <= mix_en;
        s1_cplx <= cplx_mode;
        s1_i    <= in_i;
        s1_q    <= in_q;
      end
    end
  end

  nco_cmult #(.DATA_W(DATA_W)) u_mult (
    .clk   (clk),
    .rst_n (rst_n),
    .v1    (s1_v),
    .en1   (s1_en),
    .cplx1 (s1_cplx),
    .i1    (s1_i),
    .q1    (s1_q),
    .c1    (tone_cos),
    .s1    (tone_sin),
    .v_out (out_valid),
    .i_out (out_i),
    .q_out (out_q)
  );

  // cycles since reset release, so $past never reaches before it
  logic [1:0] warm_cnt;
  logic       warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           warm_cnt <= '0;
    else if (!(&warm_cnt)) warm_cnt <= warm_cnt + 2'd1;
  end
  assign warm = &warm_cnt;

  // R8: fixed three-cycle strobe latency
  p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> out_valid == $past(in_valid, 3));

  // R9: a bypassed sample emerges unchanged
  p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid, 3) && !$past(mix_en, 3)) |->
      (out_i == $past(in_i, 3) && out_q == $past(in_q, 3)));

endmodule

// File: tb/nco_mixer_tb.sv
module nco_mixer_tb;

  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [W-1:0] in_i, in_q;
  logic [11:0] tune_word;
  logic cplx_mode, mix_en;
  logic out_valid;
  logic signed [W-1:0] out_i, out_q;

  always #2 clk = ~clk;  // 250 MHz

  nco_mixer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .tune_word(tune_word), .cplx_mode(cplx_mode), .mix_en(mix_en),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int ph = 0;
  bit done = 0;

  int    exp_i[$], exp_q[$], exp_c[$];
  string exp_t[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint tone(input int k, input bit want_sin);
    real a, v;
    a = 6.283185307179586 * k / 256.0;
    v = (want_sin ? $sin(a) : $cos(a)) * 32767.0;
    if (v >= 0.0) return longint'($rtoi(v + 0.5));
    return -longint'($rtoi(0.5 - v));
  endfunction

  function automatic int scale(input longint s);
    longint r;
    r = (s + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic check(input string tag, input bit ok, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic push_drive(input int i, input int q, input int f, input bit m, input bit e,
                            input int ei, input int eq, input string tag);
    in_valid = 1'b1; in_i = W'(i); in_q = W'(q);
    tune_word = 12'(f); cplx_mode = m; mix_en = e;
    exp_i.push_back(ei); exp_q.push_back(eq); exp_c.push_back(cyc + 3); exp_t.push_back(tag);
    ph = (ph + f) & 4095;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // model expectation from R2..R7 and R9
  task automatic send(input int i, input int q, input int f, input bit m, input bit e, input string tag);
    longint c, s, qe;
    int ei, eq;
    c  = tone(ph >> 4, 1'b0);
    s  = tone(ph >> 4, 1'b1);
    qe = m ? longint'(q) : 0;
    if (e) begin
      ei = scale(longint'(i) * c + qe * s);
      eq = scale(qe * c - longint'(i) * s);
    end else begin
      ei = i; eq = q;
    end
    push_drive(i, q, f, m, e, ei, eq, tag);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0; tune_word = 12'd777; in_i = 16'sd1234; in_q = -16'sd99;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic set_phase(input int target);
    send(300, -200, (target - ph) & 4095, 1'b1, 1'b1, "R2");
  endtask

  // scoreboard at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      if (exp_i.size() == 0) begin
        check("R8", 1'b0, $sformatf("unexpected out_valid got i=%0d q=%0d expected no sample", out_i, out_q));
      end else begin
        int ei, eq, ec;
        string t;
        ei = exp_i.pop_front(); eq = exp_q.pop_front(); ec = exp_c.pop_front(); t = exp_t.pop_front();
        check(t, (int'(out_i) == ei) && (int'(out_q) == eq) && (cyc == ec),
              $sformatf("got i=%0d q=%0d cyc=%0d expected i=%0d q=%0d cyc=%0d",
                        out_i, out_q, cyc, ei, eq, ec));
      end
    end
  end

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0;
    tune_word = '0; cplx_mode = 1'b0; mix_en = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", out_valid == 1'b0 && out_i == 0 && out_q == 0,
          $sformatf("in reset got v=%0d i=%0d q=%0d expected 0 0 0", out_valid, out_i, out_q));
    @(posedge clk); #1; rst_n = 1'b1;
    idle(3);
    @(negedge clk);
    check("R1", out_valid == 1'b0 && out_i == 0 && out_q == 0,
          $sformatf("after release got v=%0d i=%0d q=%0d expected 0 0 0", out_valid, out_i, out_q));
    @(posedge clk); #1;
  endtask

  // R9, R8: bypass keeps data and latency, phase keeps stepping
  task automatic t_bypass;
    send(  111, -222, 100, 1'b1, 1'b0, "R9");
    send(-32768, 32767, 250, 1'b0, 1'b0, "R9");
    idle(2);
    send(  5, 6, 1000, 1'b1, 1'b0, "R9");
    send(  700, 900, 0, 1'b1, 1'b1, "R9");  // mixed with phase advanced by the bypassed words
    idle(5);
  endtask

  // R5, R3: phase 0, real mode ignores Q
  task automatic t_real_dc;
    set_phase(0);
    push_drive(1000, 5000, 0, 1'b0, 1'b1, 1000, 0, "R5");
    push_drive(-1000, -32768, 0, 1'b0, 1'b1, -1000, 0, "R5");
    idle(5);
  endtask

  // R4, R3: phase 90 degrees, cos 0, sin 32767
  task automatic t_quarter;
    set_phase(1024);
    push_drive(1000, 2000, 0, 1'b1, 1'b1, 2000, -1000, "R4");
    idle(5);
  endtask

  // R7: 45 degrees, full-scale equal inputs overflow the sample range
  task automatic t_sat;
    set_phase(512);
    push_drive(-32768, -32768, 0, 1'b1, 1'b1, -32768, 0, "R7");
    push_drive(32767, 32767, 0, 1'b1, 1'b1, 32767, 0, "R7");
    idle(5);
  endtask

  // R2: idle cycles with a stray word do not move the phase
  task automatic t_gaps;
    for (int n = 0; n < 12; n++) begin
      send(10000 - n * 1500, 3000 + n * 700, 300, 1'b1, 1'b1, "R2");
      idle(n % 3 + 1);
    end
    idle(5);
  endtask

  // R4, R6, R10: varied words, per-sample mode and enable
  task automatic t_mixed;
    for (int n = 0; n < 60; n++) begin
      int i, q, f;
      i = $urandom_range(65535) - 32768;
      q = $urandom_range(65535) - 32768;
      f = $urandom_range(4095);
      send(i, q, f, n[0], (n % 5) != 4, (n % 5) == 4 ? "R10" : (n[0] ? "R4" : "R6"));
    end
    idle(6);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_real_dc();
    t_quarter();
    t_sat();
    t_gaps();
    t_mixed();
    idle(6);
    check("R8", exp_i.size() == 0,
          $sformatf("samples outstanding got %0d expected 0", exp_i.size()));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule